// File: doc/BRIEF.md
# Audio Transmit Sample Queue with Slot Packing

This block sits in the transmit path of a serial audio link controller. Software writes sample words through a register bus. Each word is converted to the 20-bit left-justified slot format and then placed in a circular queue. The conversion depends on the configured sample width. In compact mode a single 32-bit write carries two 16-bit samples. The queue drains toward a codec-side sink as left/right pairs over a valid/ready handshake. Draining starts only once the queue is at least half full. From then on it continues pair after pair until the sink declines a pair or fewer than two entries remain.

Four sticky status flags follow set and clear rules that differ between pushes and pops: empty, half-empty, full and underrun. These flags feed three raw interrupt sources. A mask selects which sources drive the single interrupt output. A control write registers the enable, the sample width code, compact mode and the slot selection. Those settings apply from the cycle after the write.

Top module: `audio_tx_fifo`

## Requirements
- R1: A non-compact word is stored as one sample, shifted left and truncated to its low 20 bits. The width code on `ctrl_size` sets the shift: code 3 (12-bit) shifts by 8, code 0 (16-bit) by 4, code 1 (18-bit) by 2, and code 2 (20-bit) by 0.
- R2: In compact mode a write yields two samples, bits 15:0 first and bits 31:16 second. Each is shifted left by 8 for code 3 and by 4 otherwise, keeping 20 bits. A control write that requests compact mode with code 1 or 2 stores compact mode as off.
- R3: A non-compact write is dropped when the level equals DEPTH. A compact write is accepted only when the level plus 2 is strictly below DEPTH, so compact writes alone never reach full.
- R4: `out_valid` is high only when the channel is enabled, at least one bit of `ctrl_slots` is set and the level is at least 2. It also needs either the level to be at least DEPTH/2 or a pair to have been popped in the previous cycle. `out_left` is the oldest entry and `out_right` the next one. One pair is removed per cycle in which `out_valid` and `sink_ready` are both high.
- R5: A cycle with `out_valid` high and `sink_ready` low ends the drain burst. Further draining then needs the level to reach DEPTH/2 again.
- R6: After an accepted push, a non-zero new level clears empty and underrun. A new level of at least DEPTH/2 clears half-empty, and a new level of DEPTH sets full.
- R7: After a pop, full clears and half-empty sets when the new level is at most DEPTH/2. Empty and underrun both set when the new level is 0.
- R8: When a push and a pop happen in the same cycle, the level changes once by their net amount. The push rules are applied first and then the pop rules, both using the new level.
- R9: A write to the clear port with `clr_underrun` high clears underrun, unless a pop in the same cycle empties the queue.
- R10: `irq_raw` bit 0 is underrun, bit 1 is half-empty, and bit 2 is empty while `out_valid` is low (transmit complete). `irq` is the OR of `irq_raw & irq_mask`.
- R11: After reset the level is 0, empty and half-empty are set, full and underrun are clear, and the channel is disabled.
- R12: Control settings take effect from the cycle after the control write. Pushes and drain decisions in the write cycle use the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_enable | input | 1 | Channel enable |
| ctrl_size | input | 2 | Sample width code (0:16, 1:18, 2:20, 3:12 bit) |
| ctrl_compact | input | 1 | Two 16-bit samples per write |
| ctrl_slots | input | 2 | Active transmit slot selection (either bit enables draining) |
| wr_en | input | 1 | Sample word write strobe |
| wr_data | input | 32 | Sample word |
| clr_we | input | 1 | Interrupt clear write strobe |
| clr_underrun | input | 1 | Clear the underrun flag |
| irq_mask | input | 3 | Interrupt enable per raw source |
| sink_ready | input | 1 | Sink accepts the offered pair |
| out_valid | output | 1 | A left/right pair is offered |
| out_left | output | 20 | Left sample (oldest entry) |
| out_right | output | 20 | Right sample |
| fifo_level | output | LVL_W (4 at DEPTH=8) | Entries held |
| st_empty | output | 1 | Empty flag |
| st_half | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |
| irq_raw | output | 3 | Raw interrupt sources |
| irq | output | 1 | Masked interrupt |

## Verification
A pointer or level that drifts shows up on `fifo_level` right after the edge where the push or pop happens. It also shows up one drain later as wrong `out_left`/`out_right` words, so the bench pushes distinct words with different width codes and compares each popped pair. Flag errors show in the cycle after the update. The bench visits the same level (DEPTH/2) once through a push and once through a pop, because half-empty must differ between the two paths. A burst-tracking fault appears as a pop one cycle after a refused pair, or as a stall below half level in mid-burst; the table drives both sequences and checks the level after each.

// File: rtl/atx_pkg.sv
package atx_pkg;
    localparam int SAMPLE_W = 20;

    typedef enum logic [1:0] {
        SZ16 = 2'd0,
        SZ18 = 2'd1,
        SZ20 = 2'd2,
        SZ12 = 2'd3
    } sz_e;

    typedef struct packed {
        logic       en;
        sz_e        size;
        logic       compact;
        logic [1:0] slots;
    } ctrl_t;

    typedef struct packed {
        logic empty;
        logic half;
        logic full;
        logic underrun;
    } flags_t;
endpackage

// File: rtl/atx_packer.sv
module atx_packer
    import atx_pkg::*;
#(
    parameter int SW = SAMPLE_W
) (
    input  logic [31:0]   word,
    input  sz_e           size,
    input  logic          compact,
    output logic [SW-1:0] s0,
    output logic [SW-1:0] s1,
    output logic [1:0]    count
);
    logic [4:0]           full_sh;
    logic [4:0]           lane_sh;
    logic [SW-1:0]        whole;
    logic [1:0][SW-1:0]   lane_s;

    always_comb begin
        unique case (size)
            SZ12:    full_sh = 5'd8;
            SZ16:    full_sh = 5'd4;
            SZ18:    full_sh = 5'd2;
            default: full_sh = 5'd0;
        endcase
        lane_sh = (size == SZ12) ? 5'd8 : 5'd4;
        whole   = SW'(word << full_sh);
    end

    // two 16-bit lanes, low half is the first sample
    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_s[g] = SW'({16'h0, word[16*g +: 16]} << lane_sh);
    end

    always_comb begin
        s0    = compact ? lane_s[0] : whole;
        s1    = lane_s[1];
        count = compact ? 2'd2 : 2'd1;
    end
endmodule

// File: rtl/atx_store.sv
module atx_store #(
    parameter  int DEPTH = 8,
    parameter  int SW    = 20,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       push_n,
    input  logic [SW-1:0]    s0,
    input  logic [SW-1:0]    s1,
    input  logic             pop,
    output logic [SW-1:0]    rd_left,
    output logic [SW-1:0]    rd_right,
    output logic [LVL_W-1:0] level_q,
    output logic [LVL_W-1:0] level_d
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] level;
    } st_t;

    st_t              st_d, st_q;
    logic [SW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_next1;
    logic [PTR_W-1:0] rd_next1;

    always_comb begin
        wr_next1 = st_q.wr + PTR_W'(1);
        rd_next1 = st_q.rd + PTR_W'(1);
        st_d     = st_q;
        st_d.wr  = st_q.wr + PTR_W'(push_n);
        if (pop) begin
            st_d.rd = st_q.rd + PTR_W'(2);
        end
        st_d.level = st_q.level + LVL_W'(push_n) - (pop ? LVL_W'(2) : LVL_W'(0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) begin
            mem[st_q.wr] <= s0;
        end
        if (push_n == 2'd2) begin
            mem[wr_next1] <= s1;
        end
    end

    assign rd_left  = mem[st_q.rd];
    assign rd_right = mem[rd_next1];
    assign level_q  = st_q.level;
    assign level_d  = st_d.level;
endmodule

// File: rtl/atx_status.sv
module atx_status
    import atx_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             clr_ur,
    input  logic [LVL_W-1:0] level_d,
    output flags_t           flags_q
);
    localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (clr_ur) begin
            flags_d.underrun = 1'b0;
        end
        if (push) begin
            if (level_d != '0) begin
                flags_d.empty    = 1'b0;
                flags_d.underrun = 1'b0;
            end
            if (level_d >= HALF) flags_d.half = 1'b0;
            if (level_d >= FULL) flags_d.full = 1'b1;
        end
        if (pop) begin
            flags_d.full = 1'b0;
            if (level_d <= HALF) flags_d.half = 1'b1;
            if (level_d == '0) begin
                flags_d.empty    = 1'b1;
                flags_d.underrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '{empty: 1'b1, half: 1'b1, full: 1'b0, underrun: 1'b0};
        end else begin
            flags_q <= flags_d;
        end
    end
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
    import atx_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int SW    = SAMPLE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             ctrl_enable,
    input  logic [1:0]       ctrl_size,
    input  logic             ctrl_compact,
    input  logic [1:0]       ctrl_slots,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             clr_we,
    input  logic             clr_underrun,
    input  logic [2:0]       irq_mask,
    input  logic             sink_ready,
    output logic             out_valid,
    output logic [SW-1:0]    out_left,
    output logic [SW-1:0]    out_right,
    output logic [LVL_W-1:0] fifo_level,
    output logic             st_empty,
    output logic             st_half,
    output logic             st_full,
    output logic             st_underrun,
    output logic [2:0]       irq_raw,
    output logic             irq
);
    localparam logic [LVL_W-1:0] HALF   = LVL_W'(DEPTH / 2);
    localparam logic [LVL_W-1:0] FULL   = LVL_W'(DEPTH);
    localparam logic [LVL_W:0]   FULL_X = (LVL_W + 1)'(DEPTH);

    typedef struct packed {
        ctrl_t ctrl;
        logic  burst;
    } top_t;

    top_t             top_d, top_q;
    logic [SW-1:0]    s0, s1;
    logic [1:0]       count;
    logic [1:0]       push_n;
    logic             pop;
    logic [LVL_W-1:0] level_q, level_d;
    flags_t           flags;
    sz_e              size_in;

    atx_packer #(.SW(SW)) u_packer (
        .word    (wr_data),
        .size    (top_q.ctrl.size),
        .compact (top_q.ctrl.compact),
        .s0      (s0),
        .s1      (s1),
        .count   (count)
    );

    always_comb begin
        size_in = sz_e'(ctrl_size);
        top_d   = top_q;
        if (ctrl_we) begin
            top_d.ctrl.en      = ctrl_enable;
            top_d.ctrl.size    = size_in;
            top_d.ctrl.compact = ctrl_compact && (size_in == SZ16 || size_in == SZ12);
            top_d.ctrl.slots   = ctrl_slots;
        end

        push_n = 2'd0;
        if (wr_en) begin
            if (count == 2'd2) begin
                push_n = (({1'b0, level_q} + (LVL_W + 1)'(2)) < FULL_X) ? 2'd2 : 2'd0;
            end else begin
                push_n = (level_q < FULL) ? 2'd1 : 2'd0;
            end
        end

        out_valid = top_q.ctrl.en && (top_q.ctrl.slots != 2'b00) &&
                    (level_q >= LVL_W'(2)) && (top_q.burst || level_q >= HALF);
        pop         = out_valid && sink_ready;
        top_d.burst = pop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '{ctrl: '{en: 1'b0, size: SZ16, compact: 1'b0, slots: 2'b00},
                       burst: 1'b0};
        end else begin
            top_q <= top_d;
        end
    end

    atx_store #(.DEPTH(DEPTH), .SW(SW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_n   (push_n),
        .s0       (s0),
        .s1       (s1),
        .pop      (pop),
        .rd_left  (out_left),
        .rd_right (out_right),
        .level_q  (level_q),
        .level_d  (level_d)
    );

    atx_status #(.DEPTH(DEPTH)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push_n != 2'd0),
        .pop     (pop),
        .clr_ur  (clr_we && clr_underrun),
        .level_d (level_d),
        .flags_q (flags)
    );

    always_comb begin
        fifo_level  = level_q;
        st_empty    = flags.empty;
        st_half     = flags.half;
        st_full     = flags.full;
        st_underrun = flags.underrun;
        irq_raw     = {flags.empty && !out_valid, flags.half, flags.underrun};
        irq         = |(irq_raw & irq_mask);
    end
endmodule

// File: rtl/atx_checker.sv
module atx_checker #(
    parameter  int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] level,
    input logic             st_empty,
    input logic             st_full,
    input logic             st_underrun,
    input logic             out_valid,
    input logic             sink_ready,
    input logic             clr_we,
    input logic             clr_underrun,
    input logic [2:0]       irq_mask,
    input logic             irq
);
    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    assert_full_at_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_full |-> level == LVL_W'(DEPTH));

    assert_empty_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_empty |-> level == '0);

    assert_underrun_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_underrun) |-> (level == '0 && st_empty));

    assert_offer_has_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> level >= LVL_W'(2));

    assert_start_at_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> level >= LVL_W'(DEPTH / 2));

    assert_clear_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_underrun && !(out_valid && sink_ready)) |=> !st_underrun);

    assert_mask_gates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 3'b000) |-> !irq);
endmodule

bind audio_tx_fifo atx_checker #(.DEPTH(DEPTH)) u_atx_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .level        (fifo_level),
    .st_empty     (st_empty),
    .st_full      (st_full),
    .st_underrun  (st_underrun),
    .out_valid    (out_valid),
    .sink_ready   (sink_ready),
    .clr_we       (clr_we),
    .clr_underrun (clr_underrun),
    .irq_mask     (irq_mask),
    .irq          (irq)
);

// File: tb/tb_audio_tx_fifo.sv
`timescale 1ns/1ps
module tb_audio_tx_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0, ctrl_enable = 1'b0, ctrl_compact = 1'b0;
    logic [1:0]  ctrl_size = 2'd0, ctrl_slots = 2'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        clr_we = 1'b0, clr_underrun = 1'b0;
    logic [2:0]  irq_mask = 3'b000;
    logic        sink_ready = 1'b0;
    logic        out_valid;
    logic [19:0] out_left, out_right;
    logic [3:0]  fifo_level;
    logic        st_empty, st_half, st_full, st_underrun;
    logic [2:0]  irq_raw;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    audio_tx_fifo #(.DEPTH(8)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable),
        .ctrl_size(ctrl_size), .ctrl_compact(ctrl_compact), .ctrl_slots(ctrl_slots),
        .wr_en(wr_en), .wr_data(wr_data), .clr_we(clr_we), .clr_underrun(clr_underrun),
        .irq_mask(irq_mask), .sink_ready(sink_ready), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right), .fifo_level(fifo_level),
        .st_empty(st_empty), .st_half(st_half), .st_full(st_full),
        .st_underrun(st_underrun), .irq_raw(irq_raw), .irq(irq)
    );

    // vector: op(2) data(32) ready(1) level(4) flags{empty,half,full,underrun}(4)
    // op 0: control (bit0 enable, bits2:1 size, bit3 compact, bits5:4 slots)
    // op 1: sample write, op 2: clear (bit0 underrun), op 3: idle
    localparam int NV = 50;
    localparam logic [42:0] VEC [NV] = '{
        {2'd0, 32'h10, 1'b0, 4'd0, 4'b1100},
        {2'd1, 32'hABC, 1'b0, 4'd1, 4'b0100},   // R6 empty clears, underrun stays low
        {2'd1, 32'h1, 1'b0, 4'd2, 4'b0100},
        {2'd1, 32'h2, 1'b0, 4'd3, 4'b0100},
        {2'd1, 32'h3, 1'b0, 4'd4, 4'b0000},     // R6 half clears at DEPTH/2 by push
        {2'd1, 32'h4, 1'b0, 4'd5, 4'b0000},
        {2'd1, 32'h5, 1'b0, 4'd6, 4'b0000},
        {2'd1, 32'h6, 1'b0, 4'd7, 4'b0000},
        {2'd1, 32'h7, 1'b0, 4'd8, 4'b0010},     // R6 full
        {2'd1, 32'h99, 1'b0, 4'd8, 4'b0010},    // R3 dropped at full
        {2'd0, 32'h11, 1'b0, 4'd8, 4'b0010},    // R12 enable
        {2'd3, 32'h0, 1'b0, 4'd8, 4'b0010},     // R5 refused
        {2'd3, 32'h0, 1'b1, 4'd6, 4'b0000},     // R4 one pair, R7 full clears
        {2'd3, 32'h0, 1'b1, 4'd4, 4'b0100},     // R7 half sets at DEPTH/2 by pop
        {2'd3, 32'h0, 1'b1, 4'd2, 4'b0100},     // R5 burst continues below half
        {2'd3, 32'h0, 1'b1, 4'd0, 4'b1101},     // R7 empty + underrun
        {2'd3, 32'h0, 1'b1, 4'd0, 4'b1101},
        {2'd2, 32'h1, 1'b0, 4'd0, 4'b1100},     // R9 clear underrun
        {2'd0, 32'h01, 1'b1, 4'd0, 4'b1100},    // no slot selected
        {2'd1, 32'hA, 1'b1, 4'd1, 4'b0100},
        {2'd1, 32'hB, 1'b1, 4'd2, 4'b0100},
        {2'd1, 32'hC, 1'b1, 4'd3, 4'b0100},
        {2'd1, 32'hD, 1'b1, 4'd4, 4'b0000},
        {2'd3, 32'h0, 1'b1, 4'd4, 4'b0000},     // R4 no drain without slot
        {2'd0, 32'h21, 1'b1, 4'd4, 4'b0000},    // R12 old slots still apply
        {2'd3, 32'h0, 1'b1, 4'd2, 4'b0100},
        {2'd3, 32'h0, 1'b1, 4'd0, 4'b1101},
        {2'd0, 32'h20, 1'b0, 4'd0, 4'b1101},
        {2'd1, 32'h1, 1'b0, 4'd1, 4'b0100},     // R6 push clears underrun
        {2'd1, 32'h2, 1'b0, 4'd2, 4'b0100},
        {2'd1, 32'h3, 1'b0, 4'd3, 4'b0100},
        {2'd1, 32'h4, 1'b0, 4'd4, 4'b0000},
        {2'd0, 32'h21, 1'b0, 4'd4, 4'b0000},
        {2'd1, 32'h5, 1'b1, 4'd3, 4'b0100},     // R8 push and pop together
        {2'd3, 32'h0, 1'b1, 4'd1, 4'b0100},
        {2'd3, 32'h0, 1'b1, 4'd1, 4'b0100},
        {2'd1, 32'h6, 1'b0, 4'd2, 4'b0100},
        {2'd1, 32'h7, 1'b0, 4'd3, 4'b0100},
        {2'd1, 32'h8, 1'b1, 4'd4, 4'b0000},
        {2'd3, 32'h0, 1'b1, 4'd2, 4'b0100},
        {2'd3, 32'h0, 1'b0, 4'd2, 4'b0100},     // R5 refusal ends burst
        {2'd3, 32'h0, 1'b1, 4'd2, 4'b0100},     // R5 no restart below half
        {2'd0, 32'h08, 1'b0, 4'd2, 4'b0100},    // compact, 16-bit
        {2'd1, 32'h22221111, 1'b0, 4'd4, 4'b0000},
        {2'd1, 32'h44443333, 1'b0, 4'd6, 4'b0000},
        {2'd1, 32'h66665555, 1'b0, 4'd6, 4'b0000}, // R3 compact needs level+2 < DEPTH
        {2'd0, 32'h00, 1'b0, 4'd6, 4'b0000},
        {2'd1, 32'h9, 1'b0, 4'd7, 4'b0000},
        {2'd1, 32'hA, 1'b0, 4'd8, 4'b0010},
        {2'd1, 32'hB, 1'b0, 4'd8, 4'b0010}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after one rising edge
    task automatic step(input int op, input logic [31:0] d, input logic rdy);
        sink_ready = rdy;
        case (op)
            0: begin
                ctrl_we = 1'b1; ctrl_enable = d[0]; ctrl_size = d[2:1];
                ctrl_compact = d[3]; ctrl_slots = d[5:4];
            end
            1: begin wr_en = 1'b1; wr_data = d; end
            2: begin clr_we = 1'b1; clr_underrun = d[0]; end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        ctrl_we = 1'b0; wr_en = 1'b0; clr_we = 1'b0; clr_underrun = 1'b0;
        sink_ready = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R11 reset state
        check("R11 level", 32'(fifo_level), 0);
        check("R11 flags", 32'({st_empty, st_half, st_full, st_underrun}), 32'b1100);
        check("R11 not offering", 32'(out_valid), 0);
        irq_mask = 3'b000; #1 check("R10 all masked", 32'(irq), 0);
        irq_mask = 3'b001; #1 check("R10 underrun source low", 32'(irq), 0);
        irq_mask = 3'b010; #1 check("R10 half source", 32'(irq), 1);
        irq_mask = 3'b100; #1 check("R10 complete source", 32'(irq), 1);
        check("R10 raw", 32'(irq_raw), 32'b110);
        irq_mask = 3'b000;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(int'(VEC[i][42:41]), VEC[i][40:9], VEC[i][8]);
            check($sformatf("R6/R7 vec %0d level", i), 32'(fifo_level), 32'(VEC[i][7:4]));
            check($sformatf("R6/R7 vec %0d flags", i),
                  32'({st_empty, st_half, st_full, st_underrun}), 32'(VEC[i][3:0]));
        end

        // R1 packing per width code
        do_reset();
        step(0, 32'h16, 0);             // 12-bit
        step(1, 32'hFFFFFABC, 0);
        step(0, 32'h12, 0);             // 18-bit
        step(1, 32'h00012345, 0);
        step(0, 32'h14, 0);             // 20-bit
        step(1, 32'hFFF12345, 0);
        step(0, 32'h10, 0);             // 16-bit
        step(1, 32'h000FABCD, 0);
        step(0, 32'h11, 0);
        check("R4 offer at half", 32'(out_valid), 1);
        check("R1 12-bit left", 32'(out_left), 32'hABC00);
        check("R1 18-bit right", 32'(out_right), 32'h48D14);
        step(3, 0, 1);
        check("R4 next pair offered", 32'(out_valid), 1);
        check("R1 20-bit left", 32'(out_left), 32'h12345);
        check("R1 16-bit right", 32'(out_right), 32'hABCD0);

        // R2 compact 12-bit
        do_reset();
        step(0, 32'h1E, 0);
        step(1, 32'h0ABC0123, 0);
        check("R2 compact adds two", 32'(fifo_level), 2);
        step(1, 32'h00020001, 0);
        step(0, 32'h1F, 0);
        check("R2 low half first", 32'(out_left), 32'h12300);
        check("R2 high half second", 32'(out_right), 32'hABC00);

        // R2 compact 16-bit
        do_reset();
        step(0, 32'h18, 0);
        step(1, 32'hBEEF1234, 0);
        step(1, 32'h0, 0);
        step(0, 32'h19, 0);
        check("R2 16-bit low", 32'(out_left), 32'h12340);
        check("R2 16-bit high", 32'(out_right), 32'hBEEF0);

        // R2 compact forced off for 18 and 20 bit
        do_reset();
        step(0, 32'h0A, 0);
        step(1, 32'h00012345, 0);
        check("R2 18-bit compact ignored", 32'(fifo_level), 1);
        step(0, 32'h0C, 0);
        step(1, 32'h00012345, 0);
        check("R2 20-bit compact ignored", 32'(fifo_level), 2);

        // R10 underrun interrupt and R9 clear
        do_reset();
        step(0, 32'h11, 0);
        for (int k = 0; k < 4; k++) step(1, 32'(k), 0);
        irq_mask = 3'b001;
        step(3, 0, 1);
        step(3, 0, 1);
        check("R10 underrun irq", 32'(irq), 1);
        step(2, 32'h1, 0);
        check("R9 underrun cleared irq", 32'(irq), 0);
        irq_mask = 3'b100;
        #1 check("R10 complete when empty", 32'(irq), 1);
        irq_mask = 3'b000;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule